// File: doc/BRIEF.md
# Partitioned Saturating SIMD Adder

This block adds or subtracts two 64-bit operands in one of two shapes. In wide mode it is a single 64-bit two's-complement adder/subtractor, with the carry running through all 64 bits. In lane mode the word is split into four independent 16-bit lanes. Each lane is a signed fixed-point value with its binary point just below the sign bit, so it can hold values from -1 up to 1-2^-15. All four lanes are computed in the same cycle, and no carry or borrow passes from one lane into the next.

In lane mode each lane can either wrap modulo 2^16 or saturate. When it saturates, an overflowing lane is clamped to the nearest representable limit instead of wrapping. Signed overflow is flagged per lane in both cases. The result, the flags and a valid strobe are registered, so the latency is one cycle. The output registers keep their last contents until the next operation is accepted.

Top module: `simd_part_add`

## Requirements
- R1: `out_valid` is high in exactly the cycles that follow a rising clock edge at which `in_valid` was high, so the latency is one cycle.
- R2: While `rst_n` is low, `out_valid`, `result` and `lane_ovf` are all zero.
- R3: In wide mode (`part_mode`=0) with `sub`=0, `result` is `op_a + op_b` modulo 2^64, and carries cross bits 15/16, 31/32 and 47/48.
- R4: In wide mode with `sub`=1, `result` is `op_a - op_b` modulo 2^64, and borrows cross the 16-bit boundaries.
- R5: In wide mode, `lane_ovf[3]` flags 64-bit signed overflow and `lane_ovf[2:0]` are zero. `sat_en` has no effect in wide mode.
- R6: In lane mode (`part_mode`=1) with `sub`=0, lane i (bits 16i+15..16i) of `result` depends only on lane i of the two operands, and no carry enters from lane i-1.
- R7: In lane mode with `sub`=1, each lane is `a - b` of its own lane, and no borrow passes between lanes.
- R8: In lane mode, `lane_ovf[i]` is set when the exact signed result of lane i lies outside -32768..32767. The flag is reported whether or not `sat_en` is set.
- R9: In lane mode with `sat_en`=1, a lane that overflows upward returns 0x7FFF, and a lane that overflows downward returns 0x8000.
- R10: In lane mode with `sat_en`=0, every lane wraps modulo 2^16.
- R11: While `in_valid` is low, `result` and `lane_ovf` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand (subtrahend when `sub`=1) |
| sub | input | 1 | 0 = add, 1 = subtract |
| part_mode | input | 1 | 0 = one 64-bit word, 1 = four 16-bit lanes |
| sat_en | input | 1 | Saturate lanes on overflow (lane mode only) |
| out_valid | output | 1 | Result registers were loaded at the last edge |
| result | output | 64 | Registered sum or difference |
| lane_ovf | output | 4 | Per-lane signed overflow (bit 3 is the word flag in wide mode) |

## Verification
The assertions assume that the operands and the controls are known values at every edge where `in_valid` is high. They also assume that `in_valid` is low for the whole time reset is asserted, because the valid and hold properties compare against the previous cycle. The stimulus meets these assumptions: it changes all inputs only on falling edges, keeps `in_valid` low through reset, and drops `in_valid` only between complete operations. Within that envelope, it pairs the lane boundary values (0x7FFF, 0x8000, 0xFFFF, 0x0000) in every mode combination. It then sends random words, with the four modes interleaved, so that carries and flags in neighbouring lanes disagree.

// File: rtl/simd_add_pkg.sv
package simd_add_pkg;
    localparam int LANE_W  = 16;
    localparam int LANES   = 4;
    localparam int WORD_W  = LANE_W * LANES;

    typedef enum logic {
        SHAPE_WIDE  = 1'b0,
        SHAPE_LANES = 1'b1
    } shape_e;
endpackage

// File: rtl/simd_lane_add.sv
// One lane slice: adds a and b (or a and ~b with a carry in of 1), and
// raises a signed overflow flag using the sign rule on the effective operands.
module simd_lane_add #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf,
    output logic         a_neg
);
    logic [W-1:0] b_eff;
    logic [W:0]   full;

    always_comb begin
        b_eff = sub ? ~b : b;
        full  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
        sum   = full[W-1:0];
        cout  = full[W];
        a_neg = a[W-1];
        ovf   = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
    end
endmodule

// File: rtl/simd_lane_sat.sv
// Clamps one lane to the signed limits when overflow occurred and clamping is on.
module simd_lane_sat #(
    parameter int W = 16
) (
    input  logic [W-1:0] raw,
    input  logic         ovf,
    input  logic         a_neg,
    input  logic         clamp_en,
    output logic [W-1:0] res
);
    localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MAX_NEG = {1'b1, {(W-1){1'b0}}};

    always_comb begin
        if (clamp_en && ovf) begin
            res = a_neg ? MAX_NEG : MAX_POS;
        end else begin
            res = raw;
        end
    end
endmodule

// File: rtl/simd_out_stage.sv
// Output register stage: loads on accepted input, holds otherwise.
module simd_out_stage #(
    parameter int DW = 64,
    parameter int FW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] d_res,
    input  logic [FW-1:0] d_flag,
    output logic          q_valid,
    output logic [DW-1:0] q_res,
    output logic [FW-1:0] q_flag
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid <= 1'b0;
            q_res   <= '0;
            q_flag  <= '0;
        end else begin
            q_valid <= load;
            if (load) begin
                q_res  <= d_res;
                q_flag <= d_flag;
            end
        end
    end
endmodule

// File: rtl/simd_part_add.sv
module simd_part_add
    import simd_add_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    input  logic              sub,
    input  logic              part_mode,
    input  logic              sat_en,
    output logic              out_valid,
    output logic [WORD_W-1:0] result,
    output logic [LANES-1:0]  lane_ovf
);
    shape_e            shape;
    logic [LANES-1:0]  carry_in;
    logic [LANES-1:0]  carry_out;
    logic [LANES-1:0]  raw_ovf;
    logic [LANES-1:0]  sign_a;
    logic [LANES-1:0]  flag_d;
    logic [WORD_W-1:0] raw_sum;
    logic [WORD_W-1:0] res_d;
    logic              clamp_en;

    assign shape    = shape_e'(part_mode);
    assign clamp_en = (shape == SHAPE_LANES) && sat_en;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        if (i == 0) begin : g_first
            assign carry_in[i] = sub;
        end else begin : g_rest
            // Lane shape cuts the chain; wide shape forwards the carry.
            assign carry_in[i] = (shape == SHAPE_LANES) ? sub : carry_out[i-1];
        end

        simd_lane_add #(.W(LANE_W)) u_add (
            .a     (op_a[LANE_W*i +: LANE_W]),
            .b     (op_b[LANE_W*i +: LANE_W]),
            .sub   (sub),
            .cin   (carry_in[i]),
            .sum   (raw_sum[LANE_W*i +: LANE_W]),
            .cout  (carry_out[i]),
            .ovf   (raw_ovf[i]),
            .a_neg (sign_a[i])
        );

        simd_lane_sat #(.W(LANE_W)) u_sat (
            .raw      (raw_sum[LANE_W*i +: LANE_W]),
            .ovf      (raw_ovf[i]),
            .a_neg    (sign_a[i]),
            .clamp_en (clamp_en),
            .res      (res_d[LANE_W*i +: LANE_W])
        );

        if (i == LANES - 1) begin : g_top_flag
            assign flag_d[i] = raw_ovf[i];
        end else begin : g_low_flag
            assign flag_d[i] = (shape == SHAPE_LANES) ? raw_ovf[i] : 1'b0;
        end
    end

    simd_out_stage #(.DW(WORD_W), .FW(LANES)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (in_valid),
        .d_res   (res_d),
        .d_flag  (flag_d),
        .q_valid (out_valid),
        .q_res   (result),
        .q_flag  (lane_ovf)
    );
endmodule

// File: rtl/simd_part_add_chk.sv
module simd_part_add_chk
    import simd_add_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [WORD_W-1:0] op_a,
    input logic [WORD_W-1:0] op_b,
    input logic              sub,
    input logic              part_mode,
    input logic              sat_en,
    input logic              out_valid,
    input logic [WORD_W-1:0] result,
    input logic [LANES-1:0]  lane_ovf
);
    a_r1_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid));

    a_r11_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> ($stable(result) && $stable(lane_ovf)));

    a_r5_wide_low_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(part_mode)) |-> (lane_ovf[LANES-2:0] == '0));

    a_r3_wide_add: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(!part_mode && !sub)) |-> (result == $past(op_a + op_b)));

    for (genvar i = 0; i < LANES; i++) begin : g_chk
        a_r9_clamp_value: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && $past(part_mode && sat_en) && lane_ovf[i]) |->
            (result[LANE_W*i +: LANE_W] == 16'h7FFF || result[LANE_W*i +: LANE_W] == 16'h8000));

        a_r6_lane_wrap_add: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && $past(part_mode && !sat_en && !sub)) |->
            (result[LANE_W*i +: LANE_W] == $past(op_a[LANE_W*i +: LANE_W] + op_b[LANE_W*i +: LANE_W])));

        a_r7_lane_wrap_sub: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && $past(part_mode && !sat_en && sub)) |->
            (result[LANE_W*i +: LANE_W] == $past(op_a[LANE_W*i +: LANE_W] - op_b[LANE_W*i +: LANE_W])));
    end
endmodule

bind simd_part_add simd_part_add_chk u_chk (.*);

// File: tb/tb_simd_part_add.sv
module tb_simd_part_add;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic        sub = 1'b0;
    logic        part_mode = 1'b0;
    logic        sat_en = 1'b0;
    logic        out_valid;
    logic [63:0] result;
    logic [3:0]  lane_ovf;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [63:0] res;
        logic [3:0]  ovf;
        string       req;
    } exp_t;

    exp_t        sb_q[$];
    logic [63:0] last_res = '0;
    logic [3:0]  last_ovf = '0;
    bit          seen = 1'b0;

    always #2 clk = ~clk;

    simd_part_add dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .sub(sub), .part_mode(part_mode), .sat_en(sat_en),
        .out_valid(out_valid), .result(result), .lane_ovf(lane_ovf)
    );

    function automatic exp_t model(logic [63:0] a, logic [63:0] b, logic s,
                                   logic p, logic sat, string req);
        exp_t e;
        e.req = req;
        e.ovf = '0;
        if (!p) begin
            logic signed [64:0] w;
            w = s ? ($signed({a[63], a}) - $signed({b[63], b}))
                  : ($signed({a[63], a}) + $signed({b[63], b}));
            e.res = w[63:0];
            e.ovf[3] = w[64] ^ w[63];
        end else begin
            for (int i = 0; i < 4; i++) begin
                int x, y, r;
                logic [31:0] rv;
                x = int'($signed(a[16*i +: 16]));
                y = int'($signed(b[16*i +: 16]));
                r = s ? x - y : x + y;
                rv = r;
                e.ovf[i] = (r > 32767) || (r < -32768);
                if (e.ovf[i] && sat) e.res[16*i +: 16] = (r > 0) ? 16'h7FFF : 16'h8000;
                else                 e.res[16*i +: 16] = rv[15:0];
            end
        end
        return e;
    endfunction

    task automatic check(string req, string what, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic drive(logic [63:0] a, logic [63:0] b, logic s, logic p,
                         logic sat, string req);
        @(negedge clk);
        op_a = a; op_b = b; sub = s; part_mode = p; sat_en = sat; in_valid = 1'b1;
        sb_q.push_back(model(a, b, s, p, sat, req));
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            op_a = $urandom(); op_b = {$urandom(), $urandom()};
        end
    endtask

    // Monitor: compares each registered result against the queue head.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_valid) begin
                if (sb_q.size() == 0) begin
                    check("R1", "unexpected out_valid", 64'd1, 64'd0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(e.req, "result", result, e.res);
                    check(e.req, "lane_ovf", {60'd0, lane_ovf}, {60'd0, e.ovf});
                    last_res = e.res; last_ovf = e.ovf; seen = 1'b1;
                end
            end else if (seen) begin
                check("R11", "held result", result, last_res);
                check("R11", "held lane_ovf", {60'd0, lane_ovf}, {60'd0, last_ovf});
            end
        end
    end

    initial begin
        int wd = 0;
        while (!done && wd < 100000) begin
            @(posedge clk);
            wd++;
        end
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R2", "reset out_valid", {63'd0, out_valid}, 64'd0);
        check("R2", "reset result", result, 64'd0);
        check("R2", "reset lane_ovf", {60'd0, lane_ovf}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(1);
        check("R1", "out_valid idle", {63'd0, out_valid}, 64'd0);

        // Wide mode: carries and borrows across lane boundaries
        drive(64'h0000_FFFF_FFFF_FFFF, 64'h1, 1'b0, 1'b0, 1'b0, "R3");
        drive(64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 1'b0, 1'b0, 1'b1, "R3");
        drive(64'h0001_0000_0000_0000, 64'h1, 1'b1, 1'b0, 1'b0, "R4");
        drive(64'h0, 64'h1, 1'b1, 1'b0, 1'b1, "R4");
        drive(64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 1'b0, 1'b0, 1'b1, "R5");
        drive(64'h8000_0000_0000_0000, 64'h1, 1'b1, 1'b0, 1'b1, "R5");
        drive(64'h7FFF_7FFF_7FFF_7FFF, 64'h0001_0001_0001_0001, 1'b0, 1'b0, 1'b1, "R5");
        idle(2);
        // Lane mode, wrap: no carry or borrow crosses lanes
        drive(64'hFFFF_FFFF_FFFF_FFFF, 64'h0001_0001_0001_0001, 1'b0, 1'b1, 1'b0, "R6");
        drive(64'h0000_0000_0000_0000, 64'h0001_0000_0001_0000, 1'b1, 1'b1, 1'b0, "R7");
        drive(64'h7FFF_8000_7FFF_0001, 64'h0001_FFFF_7FFF_0001, 1'b0, 1'b1, 1'b0, "R10");
        drive(64'h8000_0000_7FFF_FFFF, 64'h0001_8000_FFFF_7FFF, 1'b1, 1'b1, 1'b0, "R8");
        // Lane mode, saturate
        drive(64'h7FFF_8000_7FFF_0001, 64'h0001_FFFF_7FFF_0001, 1'b0, 1'b1, 1'b1, "R9");
        drive(64'h8000_0000_7FFF_FFFF, 64'h0001_8000_FFFF_7FFF, 1'b1, 1'b1, 1'b1, "R9");
        drive(64'h8000_8000_4000_C000, 64'h8000_7FFF_4000_C000, 1'b0, 1'b1, 1'b1, "R8");
        idle(3);
        // Random words, modes interleaved
        for (int n = 0; n < 400; n++) begin
            logic [2:0] m;
            m = 3'($urandom());
            drive({$urandom(), $urandom()}, {$urandom(), $urandom()}, m[0], m[1], m[2],
                  m[1] ? (m[2] ? "R9" : (m[0] ? "R7" : "R6")) : (m[0] ? "R4" : "R3"));
            if (($urandom() & 7) == 0) idle(1 + ($urandom() & 3));
        end
        idle(4);
        check("R1", "queue drained", 64'(sb_q.size()), 64'd0);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule